// File: doc/BRIEF.md
# SPI In-System Programming Slave

This block is the slave half of a serial programming link. An external host can read, write and erase two small on-chip byte arrays through it. The program array holds code and the data array is an EEPROM-style store; both are modelled as register arrays inside the block. The block only listens while the active-low `resetN` input is held low. At every other time it holds its logic cleared and drives `miso` low.

The host clock `sck` is never used as a clock. The block samples it with the system clock `clk` after a two-stage synchroniser and passes it through a run-length filter. A level that does not persist long enough is discarded as a glitch. The required run depends on `fastClk`, which tells the block whether its system clock is 12 MHz or faster. Filtered edges shift in command frames of 32 bits each. The block accepts nothing that alters memory until an unlock frame has been seen. Writes and erases then run as self-timed operations, and a busy flag can be polled over the same link.

Top module: `isp_slave`

## Requirements
- R1: The block is in programming mode only while `resetN` is low. While `resetN` is high, `miso` is 0. Taking `resetN` high forgets the unlock, so a later session must unlock again before any write takes effect.
- R2: After `resetN` falls, every write and erase frame is ignored until an unlock frame has completed. Until then, read frames return 0 in their last byte.
- R3: The unlock frame is the bytes 0xAC, 0x53, any, any. In the third byte slot the block returns 0x53. In the first two slots and the last slot it returns 0.
- R4: A frame is 32 bits, most significant bit first, grouped as opcode, address high, address low, data. `mosi` is taken on a rising `sck` edge, and `miso` changes only after a falling `sck` edge or at the end of a frame. Apart from the R3 echo, every slot other than the fourth returns 0.
- R5: The frame 0xAC, 0x80, any, any erases the chip. It writes 0xFF into every location of both arrays, one location per system clock, and busy stays high until the last location is written.
- R6: The frame 0x40, hi, lo, d writes d into the program array. The frame 0x20, hi, lo, any returns that location in the fourth slot. The array index is the low log2(PROG_DEPTH) bits of {hi,lo}.
- R7: The frame 0xC0, hi, lo, d writes d into the data array, replacing the old byte whatever it held, with no prior erase. The frame 0xA0, hi, lo, any reads the data array. The index is the low log2(EE_DEPTH) bits of {hi,lo}.
- R8: After a byte write, busy stays high for WRITE_CYCLES system clocks. The frame 0xF0, any, any, any returns busy in bit 0 of the fourth slot. Any write or erase frame that completes while busy is high is dropped.
- R9: An `sck` level is accepted only after it has been seen for 3 consecutive clocks when `fastClk` is 0, or 4 when `fastClk` is 1. A shorter pulse is ignored. Phases of exactly that length are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the link |
| resetN | input | 1 | Active low; low selects programming mode, high clears the block |
| fastClk | input | 1 | 1 when the system clock is 12 MHz or faster |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
Directed frames are applied first, and each one separates a single rule from its neighbours:
- A write sent before unlocking shows whether gating works, because a later read returns the erased value.
- Two data-array writes with complementary bit patterns show whether a write truly replaces the old byte or only clears bits.
- A second write and an erase that arrive within the busy window show whether the drop rule holds.
- Glitch pulses one clock shorter than the threshold, and frames built from minimum-length phases, bracket the filter at both clock settings.

After that, seeded random reads and writes to both arrays, with random 16-bit addresses, exercise address folding against a bench model of the two arrays.

// File: rtl/isp_pkg.sv
package isp_pkg;

  // Command bytes (first byte of a frame) and unlock/erase second bytes.
  localparam logic [7:0] OP_UNLOCK  = 8'hAC;
  localparam logic [7:0] SUB_UNLOCK = 8'h53;
  localparam logic [7:0] SUB_ERASE  = 8'h80;
  localparam logic [7:0] OP_RD_PROG = 8'h20;
  localparam logic [7:0] OP_WR_PROG = 8'h40;
  localparam logic [7:0] OP_RD_DATA = 8'hA0;
  localparam logic [7:0] OP_WR_DATA = 8'hC0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  localparam int FRAME_BITS = 32;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shiftIn;    // filtered rising edge: take one bit
    logic txStep;     // filtered falling edge: present next bit
    logic frameDone;  // 32nd bit taken this cycle
    logic progWr;     // commit program byte write
    logic dataWr;     // commit data byte write
    logic eraseStep;  // write 0xFF at erase pointer
  } isp_strobe_t;

endpackage

// File: rtl/isp_link_sync.sv
module isp_link_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_NEED   = 3,
  parameter int FAST_NEED   = 4
) (
  input  logic clk,
  input  logic resetN,
  input  logic fastClk,
  input  logic sckIn,
  input  logic mosiIn,
  output logic riseEvt,
  output logic fallEvt,
  output logic sckLevel,
  output logic mosiBit
);

  localparam int MAX_NEED = (FAST_NEED > SLOW_NEED) ? FAST_NEED : SLOW_NEED;
  localparam int CNT_W    = $clog2(MAX_NEED + 1);

  logic [SYNC_STAGES-1:0] sckSync;
  logic [SYNC_STAGES-1:0] mosiSync;
  logic                   sckRaw;
  logic                   sckRawPrev;
  logic [CNT_W-1:0]       runCnt;
  logic [CNT_W-1:0]       needM1;
  logic                   flip;

  assign sckRaw = sckSync[SYNC_STAGES-1];
  assign needM1 = fastClk ? CNT_W'(FAST_NEED - 1) : CNT_W'(SLOW_NEED - 1);
  assign flip   = (sckRaw != sckLevel) && (runCnt == needM1);

  always_ff @(posedge clk or posedge resetN) begin
    if (resetN) begin
      sckSync    <= '0;
      mosiSync   <= '0;
      sckRawPrev <= 1'b0;
      sckLevel   <= 1'b0;
      runCnt     <= '0;
      riseEvt    <= 1'b0;
      fallEvt    <= 1'b0;
      mosiBit    <= 1'b0;
    end else begin
      sckSync    <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync   <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sckRawPrev <= sckRaw;
      // capture data where the raw synchronised clock first rises
      if (sckRaw && !sckRawPrev) mosiBit <= mosiSync[SYNC_STAGES-1];
      if (sckRaw == sckLevel) begin
        runCnt <= '0;
      end else if (flip) begin
        runCnt   <= '0;
        sckLevel <= sckRaw;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
      riseEvt <= flip && sckRaw;
      fallEvt <= flip && !sckRaw;
    end
  end

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int ERASE_LEN    = 64,
  parameter int PTR_W        = 7,
  parameter int WRITE_CYCLES = 1000,
  parameter int BUSY_W       = 10
) (
  input  logic             clk,
  input  logic             resetN,
  input  logic             riseEvt,
  input  logic             fallEvt,
  input  logic [15:0]      frameHead,
  output isp_strobe_t      strb,
  output logic [4:0]       bitCnt,
  output logic [PTR_W-1:0] erasePtr,
  output logic             busy,
  output logic             enabled
);

  logic [BUSY_W-1:0] busyCnt;
  logic              eraseActive;
  logic [7:0]        opc;
  logic [7:0]        sub;
  logic              frameDone;
  logic              mayAlter;
  logic              startErase;

  assign opc        = frameHead[15:8];
  assign sub        = frameHead[7:0];
  assign frameDone  = riseEvt && (bitCnt == 5'(FRAME_BITS - 1));
  assign busy       = eraseActive || (busyCnt != '0);
  assign mayAlter   = frameDone && enabled && !busy;
  assign startErase = mayAlter && (opc == OP_UNLOCK) && (sub == SUB_ERASE);

  always_comb begin
    strb           = '0;
    strb.shiftIn   = riseEvt;
    strb.txStep    = fallEvt;
    strb.frameDone = frameDone;
    strb.progWr    = mayAlter && (opc == OP_WR_PROG);
    strb.dataWr    = mayAlter && (opc == OP_WR_DATA);
    strb.eraseStep = eraseActive;
  end

  always_ff @(posedge clk or posedge resetN) begin
    if (resetN) begin
      bitCnt      <= '0;
      enabled     <= 1'b0;
      busyCnt     <= '0;
      eraseActive <= 1'b0;
      erasePtr    <= '0;
    end else begin
      if (riseEvt) bitCnt <= bitCnt + 1'b1;
      if (frameDone && (opc == OP_UNLOCK) && (sub == SUB_UNLOCK)) enabled <= 1'b1;

      if (strb.progWr || strb.dataWr) busyCnt <= BUSY_W'(WRITE_CYCLES);
      else if (busyCnt != '0)         busyCnt <= busyCnt - 1'b1;

      if (startErase) begin
        eraseActive <= 1'b1;
        erasePtr    <= '0;
      end else if (eraseActive) begin
        if (erasePtr == PTR_W'(ERASE_LEN - 1)) eraseActive <= 1'b0;
        else                                   erasePtr    <= erasePtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int EE_DEPTH   = 32,
  parameter int PTR_W      = 7
) (
  input  logic             clk,
  input  logic             resetN,
  input  isp_strobe_t      strb,
  input  logic [4:0]       bitCnt,
  input  logic             mosiBit,
  input  logic [PTR_W-1:0] erasePtr,
  input  logic             busy,
  input  logic             enabled,
  output logic [31:0]      frameNext,
  output logic             miso
);

  localparam int PAW = $clog2(PROG_DEPTH);
  localparam int EAW = $clog2(EE_DEPTH);

  logic [7:0]  progMem [PROG_DEPTH];
  logic [7:0]  dataMem [EE_DEPTH];
  logic [31:0] rxShift;
  logic [7:0]  txByte;
  logic [7:0]  slotByte;

  assign frameNext = {rxShift[30:0], mosiBit};

  always_ff @(posedge clk or posedge resetN) begin
    if (resetN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= frameNext;
  end

  // Arrays carry no reset; they keep contents across sessions.
  always_ff @(posedge clk) begin
    if (strb.eraseStep) begin
      if (erasePtr < PTR_W'(PROG_DEPTH)) progMem[erasePtr[PAW-1:0]] <= 8'hFF;
      if (erasePtr < PTR_W'(EE_DEPTH))   dataMem[erasePtr[EAW-1:0]] <= 8'hFF;
    end else begin
      if (strb.progWr) progMem[frameNext[PAW+7:8]] <= frameNext[7:0];
      if (strb.dataWr) dataMem[frameNext[EAW+7:8]] <= frameNext[7:0];
    end
  end

  // Byte to return in the slot that starts at this falling edge.
  always_comb begin
    slotByte = 8'h00;
    case (bitCnt[4:3])
      2'd2: if (rxShift[15:8] == OP_UNLOCK && rxShift[7:0] == SUB_UNLOCK)
              slotByte = SUB_UNLOCK;
      2'd3: if (enabled) begin
              case (rxShift[23:16])
                OP_RD_PROG: slotByte = progMem[rxShift[PAW-1:0]];
                OP_RD_DATA: slotByte = dataMem[rxShift[EAW-1:0]];
                OP_POLL:    slotByte = {7'd0, busy};
                default:    slotByte = 8'h00;
              endcase
            end
      default: slotByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or posedge resetN) begin
    if (resetN) begin
      txByte <= '0;
      miso   <= 1'b0;
    end else if (strb.frameDone) begin
      txByte <= '0;
      miso   <= 1'b0;
    end else if (strb.txStep) begin
      if (bitCnt[2:0] == 3'd0) begin
        txByte <= slotByte;
        miso   <= slotByte[7];
      end else begin
        miso <= txByte[3'd7 - bitCnt[2:0]];
      end
    end
  end

endmodule

// File: rtl/isp_slave.sv
module isp_slave
  import isp_pkg::*;
#(
  parameter int PROG_DEPTH   = 64,
  parameter int EE_DEPTH     = 32,
  parameter int WRITE_CYCLES = 1000,
  parameter int SLOW_NEED    = 3,
  parameter int FAST_NEED    = 4
) (
  input  logic clk,
  input  logic resetN,
  input  logic fastClk,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  localparam int ERASE_LEN = (PROG_DEPTH > EE_DEPTH) ? PROG_DEPTH : EE_DEPTH;
  localparam int PTR_W     = $clog2(ERASE_LEN) + 1;
  localparam int BUSY_W    = $clog2(WRITE_CYCLES + 1);

  isp_strobe_t      strb;
  logic             riseEvt;
  logic             fallEvt;
  logic             sckLevel;
  logic             mosiBit;
  logic [4:0]       bitCnt;
  logic [PTR_W-1:0] erasePtr;
  logic             busy;
  logic             enabled;
  logic [31:0]      frameNext;

  isp_link_sync #(
    .SYNC_STAGES(2), .SLOW_NEED(SLOW_NEED), .FAST_NEED(FAST_NEED)
  ) u_sync (
    .clk(clk), .resetN(resetN), .fastClk(fastClk), .sckIn(sck), .mosiIn(mosi),
    .riseEvt(riseEvt), .fallEvt(fallEvt), .sckLevel(sckLevel), .mosiBit(mosiBit)
  );

  isp_ctrl #(
    .ERASE_LEN(ERASE_LEN), .PTR_W(PTR_W), .WRITE_CYCLES(WRITE_CYCLES), .BUSY_W(BUSY_W)
  ) u_ctrl (
    .clk(clk), .resetN(resetN), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .frameHead(frameNext[31:16]), .strb(strb), .bitCnt(bitCnt),
    .erasePtr(erasePtr), .busy(busy), .enabled(enabled)
  );

  isp_datapath #(
    .PROG_DEPTH(PROG_DEPTH), .EE_DEPTH(EE_DEPTH), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .resetN(resetN), .strb(strb), .bitCnt(bitCnt), .mosiBit(mosiBit),
    .erasePtr(erasePtr), .busy(busy), .enabled(enabled),
    .frameNext(frameNext), .miso(miso)
  );

endmodule

// File: rtl/isp_slave_checker.sv
module isp_slave_checker
  import isp_pkg::*;
(
  input logic        clk,
  input logic        resetN,
  input isp_strobe_t strb,
  input logic        busy,
  input logic        enabled,
  input logic        sckLevel,
  input logic        riseEvt,
  input logic        fallEvt,
  input logic        miso
);

  assert_alter_needs_unlock_R2: assert property (@(posedge clk) disable iff (resetN)
    (strb.progWr || strb.dataWr || strb.eraseStep) |-> enabled);

  assert_write_only_when_idle_R8: assert property (@(posedge clk) disable iff (resetN)
    (strb.progWr || strb.dataWr) |-> !busy);

  assert_write_sets_busy_R8: assert property (@(posedge clk) disable iff (resetN)
    (strb.progWr || strb.dataWr) |=> busy);

  assert_erase_keeps_busy_R5: assert property (@(posedge clk) disable iff (resetN)
    strb.eraseStep |-> busy);

  assert_filter_min_phase_R9: assert property (@(posedge clk) disable iff (resetN)
    !$stable(sckLevel) |=> $stable(sckLevel) ##1 $stable(sckLevel));

  assert_miso_edge_timing_R4: assert property (@(posedge clk) disable iff (resetN)
    !$stable(miso) |-> ($past(fallEvt) || $past(riseEvt)));

endmodule

bind isp_slave isp_slave_checker u_chk (
  .clk(clk), .resetN(resetN), .strb(strb), .busy(busy), .enabled(enabled),
  .sckLevel(sckLevel), .riseEvt(riseEvt), .fallEvt(fallEvt), .miso(miso)
);

// File: tb/tb_isp_slave.sv
module tb_isp_slave;

  localparam int WR_CYC = 2000;
  localparam int HALF   = 10;

  logic clk = 1'b0;
  logic resetN = 1'b1;
  logic fastClk = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] progModel [64];
  logic [7:0] dataModel [32];

  always #2 clk = ~clk;

  isp_slave #(.PROG_DEPTH(64), .EE_DEPTH(32), .WRITE_CYCLES(WR_CYC)) dut (
    .clk(clk), .resetN(resetN), .fastClk(fastClk), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // glitchAt >= 0 inserts a short high pulse of glen clocks in that bit's low phase
  task automatic frame(input logic [31:0] tx, input int half, input int glitchAt,
                       input int glen, output logic [31:0] rx);
    for (int i = 0; i < 32; i++) begin
      mosi = tx[31-i];
      if (i == glitchAt) begin
        waitClk(3); sck = 1'b1; waitClk(glen); sck = 1'b0;
      end
      waitClk(half);
      rx[31-i] = miso;
      sck = 1'b1;
      waitClk(half);
      sck = 1'b0;
    end
    waitClk(2 * half);
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] op, input logic [15:0] a,
                                      input logic [7:0] d);
    return {op, a, d};
  endfunction

  task automatic send(input logic [31:0] tx, output logic [31:0] rx);
    frame(tx, HALF, -1, 0, rx);
  endtask

  task automatic readProg(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic [31:0] rx;
    send(cmd(8'h20, a, 8'h00), rx);
    check(req, rx, {24'h0, exp});
  endtask

  task automatic readData(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic [31:0] rx;
    send(cmd(8'hA0, a, 8'h00), rx);
    check(req, rx, {24'h0, exp});
  endtask

  initial begin
    waitClk(190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    void'($urandom(32'd1234));
    waitClk(10);
    check("R1 idle miso", {31'd0, miso}, 32'd0);

    // session 1
    resetN = 1'b0; waitClk(10);
    send(cmd(8'h40, 16'h0005, 8'h12), rx);       // R2 write before unlock, ignored
    readProg(16'h0005, 8'h00, "R2 read before unlock");
    send(cmd(8'hAC, 16'h5300, 8'h00), rx);
    check("R3 unlock echo", rx, 32'h0000_5300);
    send(cmd(8'hAC, 16'h8000, 8'h00), rx);       // R5 chip erase
    waitClk(200);
    readProg(16'h0005, 8'hFF, "R5 erase prog 5 (R2 write dropped)");
    readProg(16'h003F, 8'hFF, "R5 erase prog last");
    readData(16'h0000, 8'hFF, "R5 erase data first");
    readData(16'h001F, 8'hFF, "R5 erase data last");

    send(cmd(8'h40, 16'h0005, 8'h3C), rx); waitClk(WR_CYC + 50);
    readProg(16'h0005, 8'h3C, "R6 prog write/read");
    send(cmd(8'h40, 16'h0147, 8'h5A), rx); waitClk(WR_CYC + 50);
    readProg(16'h0007, 8'h5A, "R6 prog address folding");
    readProg(16'h0045, 8'h3C, "R6 prog alias read");

    send(cmd(8'hC0, 16'h0003, 8'hF0), rx); waitClk(WR_CYC + 50);
    send(cmd(8'hC0, 16'h0003, 8'h0F), rx); waitClk(WR_CYC + 50);
    readData(16'h0003, 8'h0F, "R7 data byte replaced");
    readData(16'h0023, 8'h0F, "R7 data address folding");

    send(cmd(8'hC0, 16'h0004, 8'h11), rx);
    send(cmd(8'hF0, 16'h0000, 8'h00), rx);
    check("R8 poll busy", rx, 32'h0000_0001);
    send(cmd(8'hC0, 16'h0004, 8'h22), rx);       // dropped: busy
    waitClk(WR_CYC + 50);
    send(cmd(8'hF0, 16'h0000, 8'h00), rx);
    check("R8 poll idle", rx, 32'h0000_0000);
    readData(16'h0004, 8'h11, "R8 write during busy dropped");
    send(cmd(8'h40, 16'h0009, 8'h77), rx);
    send(cmd(8'hAC, 16'h8000, 8'h00), rx);       // dropped: busy
    waitClk(WR_CYC + 50);
    readProg(16'h0009, 8'h77, "R8 erase during busy dropped");

    // R1: leaving programming mode forgets unlock
    resetN = 1'b1; waitClk(10);
    check("R1 miso low outside session", {31'd0, miso}, 32'd0);
    resetN = 1'b0; waitClk(10);
    send(cmd(8'h40, 16'h0005, 8'h00), rx);
    readProg(16'h0005, 8'h00, "R2 locked read returns zero");
    send(cmd(8'hAC, 16'h5300, 8'h00), rx);
    readProg(16'h0005, 8'h3C, "R1 unlock cleared, write ignored");

    // R9 filter
    fastClk = 1'b1;
    frame(cmd(8'h20, 16'h0005, 8'h00), HALF, 12, 3, rx);
    check("R9 fast glitch rejected", rx, 32'h0000_003C);
    fastClk = 1'b0;
    frame(cmd(8'h20, 16'h0005, 8'h00), HALF, 20, 2, rx);
    check("R9 slow glitch rejected", rx, 32'h0000_003C);
    fastClk = 1'b1;
    frame(cmd(8'h40, 16'h000A, 8'hA5), 4, -1, 0, rx); waitClk(WR_CYC + 50);
    readProg(16'h000A, 8'hA5, "R9 fast minimum phase");
    fastClk = 1'b0;
    frame(cmd(8'h40, 16'h000B, 8'h5B), 3, -1, 0, rx); waitClk(WR_CYC + 50);
    readProg(16'h000B, 8'h5B, "R9 slow minimum phase");
    fastClk = 1'b1;

    // random phase after a fresh erase (R4 R6 R7)
    send(cmd(8'hAC, 16'h8000, 8'h00), rx); waitClk(200);
    for (int k = 0; k < 64; k++) progModel[k] = 8'hFF;
    for (int k = 0; k < 32; k++) dataModel[k] = 8'hFF;
    for (int n = 0; n < 24; n++) begin
      int kind;
      logic [15:0] a;
      logic [7:0] d;
      kind = int'($urandom % 4);
      a = 16'($urandom);
      d = 8'($urandom);
      case (kind)
        0: begin send(cmd(8'h40, a, d), rx); progModel[a[5:0]] = d; waitClk(WR_CYC + 50); end
        1: begin send(cmd(8'hC0, a, d), rx); dataModel[a[4:0]] = d; waitClk(WR_CYC + 50); end
        2: readProg(a, progModel[a[5:0]], "R6 R4 random prog read");
        default: readData(a, dataModel[a[4:0]], "R7 R4 random data read");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule